// File: doc/BRIEF.md
# Cursor SRAM Load Address Sequencer

This block moves a cursor bitmap into on-chip cursor storage. Each accepted input beat carries one 32-bit ARGB pixel. The block writes that pixel to the cursor SRAM write port in the same cycle, after exchanging its red and blue byte lanes. The write address does not advance linearly. It steps by one, and it jumps ahead by a fixed offset each time the low address byte rolls over. When a masked group of address bits clears, the address reloads with the base of the second cursor RAM bank. This lets one bitmap span several 256-word segments in two banks.

A load command carries the bitmap width and height. Pixels arrive in row-major order, `width` words per row for `height` rows. A one-cycle done pulse follows the last write. A second command, fill, writes a fixed pattern to every entry of the 256-entry transparency RAM at one word per cycle. Software issues a fill and then a full reload whenever the cursor storage has been powered down. Either command may be issued at any time, and it aborts the work in progress.

Top module: `curs_sram_loader`

## Requirements
- R1: After reset, the write strobe, pixel ready, busy and done outputs are all low.
- R2: A bitmap word is written with bits 31:24 and 15:8 unchanged, input bits 7:0 placed at 23:16, and input bits 23:16 placed at 7:0.
- R3: A load command with nonzero width and height writes its first word at the first bank base (default 0x0C00) with the transparency select low. This holds even when the command arrives during a load or a fill.
- R4: After each bitmap write, the address becomes address+1. If the low 8 bits of that value are zero, the jump offset (default 0xF00) is added to it.
- R5: If the stepped address ANDed with the bank mask (default 0x30FF) is zero, the address becomes the second bank base (default 0x0D00).
- R6: A load writes exactly width×height words. Ready is high only while words remain. done pulses high for one cycle, on the cycle after the last write, with busy low.
- R7: A load command with width or height equal to zero performs no write and gives a done pulse on the next cycle.
- R8: A fill command writes 0x55555555 to transparency addresses 0 to 255 in ascending order, one per cycle, with the transparency select high and ready low. It then gives a done pulse.
- R9: A load command asserted together with a fill command starts a load. A command that aborts work in progress produces no done pulse for the aborted work.
- R10: A cycle with pixel valid low during a load performs no write and leaves the next write address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load command, one-cycle pulse |
| init_i | input | 1 | Transparency fill command, one-cycle pulse |
| width_i | input | DIM_W | Bitmap width in words, sampled with start_i |
| height_i | input | DIM_W | Bitmap height in rows, sampled with start_i |
| pix_valid_i | input | 1 | Pixel beat valid |
| pix_data_i | input | 32 | Pixel word, ARGB |
| pix_ready_o | output | 1 | Load in progress, beat accepted when valid |
| wr_en_o | output | 1 | SRAM write strobe |
| wr_tran_o | output | 1 | Write targets the transparency RAM |
| wr_addr_o | output | ADDR_W | SRAM write address |
| wr_data_o | output | 32 | SRAM write data |
| busy_o | output | 1 | A load or fill is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is the second-bank reload. It only occurs after the address has stepped through four full 256-word segments of the first bank. A 32×40 load pushes 1280 words through the block, so it crosses every segment jump and continues past the bank switch into the second bank. Irregular gaps in pixel valid are applied during that load, so address holding is also tested across the jump points. Separate runs abort a load part-way with a new load and with a fill, and they issue both commands in the same cycle to exercise priority.

// File: rtl/cursld_pkg.sv
package cursld_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_FILL = 2'd2
   } cursld_state_e;

   function automatic logic [31:0] exchange_rb(input logic [31:0] w);
      return {w[31:24], w[7:0], w[15:8], w[23:16]};
   endfunction

endpackage

// File: rtl/cursld_addr_step.sv
module cursld_addr_step #(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] BASE_A = 16'h0C00,
   parameter logic [ADDR_W-1:0] BASE_B = 16'h0D00,
   parameter logic [ADDR_W-1:0] JUMP   = 16'h0F00,
   parameter logic [ADDR_W-1:0] MASK   = 16'h30FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int SEG_W = 8;
   localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] inc;
   logic [ADDR_W-1:0] jumped;
   logic [ADDR_W-1:0] nxt;

   always_comb begin
      inc    = addr_q + ONE;
      jumped = (inc[SEG_W-1:0] == '0) ? (inc + JUMP) : inc;
      nxt    = ((jumped & MASK) == '0) ? BASE_B : jumped;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         addr_q <= BASE_A;
      else if (restart_i) addr_q <= BASE_A;
      else if (adv_i)     addr_q <= nxt;
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/cursld_dim_cnt.sv
module cursld_dim_cnt #(
   parameter int DIM_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DIM_W-1:0] width_i,
   input  logic [DIM_W-1:0] height_i,
   input  logic             adv_i,
   output logic             last_o
);

   localparam logic [DIM_W-1:0] ONE = {{(DIM_W-1){1'b0}}, 1'b1};

   logic [DIM_W-1:0] w_q, h_q, col_q, row_q;
   logic             col_end, row_end;

   assign col_end = (col_q == w_q - ONE);
   assign row_end = (row_q == h_q - ONE);
   assign last_o  = col_end && row_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q   <= '0;
         h_q   <= '0;
         col_q <= '0;
         row_q <= '0;
      end else if (load_i) begin
         w_q   <= width_i;
         h_q   <= height_i;
         col_q <= '0;
         row_q <= '0;
      end else if (adv_i) begin
         if (col_end) begin
            col_q <= '0;
            row_q <= row_q + ONE;
         end else begin
            col_q <= col_q + ONE;
         end
      end
   end

endmodule

// File: rtl/cursld_lane_map.sv
module cursld_lane_map #(
   parameter bit SWAP_RB = 1'b1
) (
   input  logic [31:0] pix_i,
   output logic [31:0] word_o
);
   import cursld_pkg::*;

   generate
      if (SWAP_RB) begin : g_swap
         assign word_o = exchange_rb(pix_i);
      end else begin : g_pass
         assign word_o = pix_i;
      end
   endgenerate

endmodule

// File: rtl/curs_sram_loader.sv
module curs_sram_loader #(
   parameter int ADDR_W = 16,
   parameter int DIM_W  = 7,
   parameter int FILL_AW = 8,
   parameter logic [ADDR_W-1:0] BANK_A_BASE = 16'h0C00,
   parameter logic [ADDR_W-1:0] BANK_B_BASE = 16'h0D00,
   parameter logic [ADDR_W-1:0] WRAP_JUMP   = 16'h0F00,
   parameter logic [ADDR_W-1:0] BANK_MASK   = 16'h30FF,
   parameter logic [31:0]       FILL_WORD   = 32'h5555_5555,
   parameter bit SWAP_RB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              init_i,
   input  logic [DIM_W-1:0]  width_i,
   input  logic [DIM_W-1:0]  height_i,
   input  logic              pix_valid_i,
   input  logic [31:0]       pix_data_i,
   output logic              pix_ready_o,
   output logic              wr_en_o,
   output logic              wr_tran_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [31:0]       wr_data_o,
   output logic              busy_o,
   output logic              done_o
);
   import cursld_pkg::*;

   localparam logic [FILL_AW-1:0] FILL_LAST = {FILL_AW{1'b1}};
   localparam logic [FILL_AW-1:0] FILL_ONE  = {{(FILL_AW-1){1'b0}}, 1'b1};

   generate
      if (ADDR_W < 14 || ADDR_W > 32) begin : g_bad_aw
         $error("ADDR_W must lie in 14..32");
      end
      if (DIM_W < 1 || DIM_W > 12) begin : g_bad_dim
         $error("DIM_W must lie in 1..12");
      end
      if (FILL_AW < 1 || FILL_AW > ADDR_W) begin : g_bad_fill
         $error("FILL_AW must lie in 1..ADDR_W");
      end
      if (BANK_B_BASE[7:0] != 8'h00) begin : g_bad_bankb
         $error("BANK_B_BASE must be segment aligned");
      end
   endgenerate

   cursld_state_e state_q, state_d;
   logic [FILL_AW-1:0] fill_idx_q;
   logic [ADDR_W-1:0]  bmp_addr;
   logic [31:0]        mapped;
   logic               bmp_last;
   logic               zero_size;
   logic               beat;
   logic               fill_go;
   logic               fill_end;
   logic               done_d;

   assign zero_size = (width_i == '0) || (height_i == '0);
   assign beat      = (state_q == ST_LOAD) && pix_valid_i;
   assign fill_go   = init_i && !start_i;
   assign fill_end  = (state_q == ST_FILL) && (fill_idx_q == FILL_LAST);

   cursld_addr_step #(
      .ADDR_W (ADDR_W),
      .BASE_A (BANK_A_BASE),
      .BASE_B (BANK_B_BASE),
      .JUMP   (WRAP_JUMP),
      .MASK   (BANK_MASK)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (start_i),
      .adv_i     (beat && !start_i),
      .addr_o    (bmp_addr)
   );

   cursld_dim_cnt #(
      .DIM_W (DIM_W)
   ) u_dim (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start_i),
      .width_i  (width_i),
      .height_i (height_i),
      .adv_i    (beat && !start_i),
      .last_o   (bmp_last)
   );

   cursld_lane_map #(
      .SWAP_RB (SWAP_RB)
   ) u_lane (
      .pix_i  (pix_data_i),
      .word_o (mapped)
   );

   always_comb begin
      state_d = state_q;
      done_d  = 1'b0;
      if (start_i) begin
         state_d = zero_size ? ST_IDLE : ST_LOAD;
         done_d  = zero_size;
      end else if (fill_go) begin
         state_d = ST_FILL;
      end else begin
         unique case (state_q)
            ST_LOAD: if (beat && bmp_last) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
            end
            ST_FILL: if (fill_end) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         fill_idx_q <= '0;
         done_o     <= 1'b0;
      end else begin
         state_q <= state_d;
         done_o  <= done_d;
         if (fill_go)                 fill_idx_q <= '0;
         else if (state_q == ST_FILL) fill_idx_q <= fill_idx_q + FILL_ONE;
      end
   end

   assign pix_ready_o = (state_q == ST_LOAD);
   assign busy_o      = (state_q != ST_IDLE);
   assign wr_tran_o   = (state_q == ST_FILL);
   assign wr_en_o     = beat || wr_tran_o;
   assign wr_addr_o   = wr_tran_o ? {{(ADDR_W-FILL_AW){1'b0}}, fill_idx_q} : bmp_addr;
   assign wr_data_o   = wr_tran_o ? FILL_WORD : mapped;

endmodule

// File: rtl/cursld_checker.sv
module cursld_checker #(
   parameter int ADDR_W = 16,
   parameter int DIM_W  = 7,
   parameter int FILL_AW = 8,
   parameter logic [ADDR_W-1:0] BANK_A_BASE = 16'h0C00,
   parameter logic [31:0]       FILL_WORD   = 32'h5555_5555,
   parameter bit SWAP_RB = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              init_i,
   input logic [DIM_W-1:0]  width_i,
   input logic [DIM_W-1:0]  height_i,
   input logic              pix_valid_i,
   input logic [31:0]       pix_data_i,
   input logic              pix_ready_o,
   input logic              wr_en_o,
   input logic              wr_tran_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [31:0]       wr_data_o,
   input logic              busy_o,
   input logic              done_o
);

   localparam logic [7:0] B1 = 8'd1;
   localparam logic [FILL_AW-1:0] F1 = {{(FILL_AW-1){1'b0}}, 1'b1};

   AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> busy_o); // R6

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R6

   AST_READY_NOT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ready_o |-> (busy_o && !wr_tran_o)); // R8

   AST_LANE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (SWAP_RB && wr_en_o && !wr_tran_o) |->
         (wr_data_o[31:24] == pix_data_i[31:24] && wr_data_o[15:8] == pix_data_i[15:8]
          && wr_data_o[23:16] == pix_data_i[7:0] && wr_data_o[7:0] == pix_data_i[23:16])); // R2

   AST_FILL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && wr_tran_o) |-> (wr_data_o == FILL_WORD)); // R8

   AST_START_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && width_i != '0 && height_i != '0) |=>
         (wr_addr_o == BANK_A_BASE && pix_ready_o && !done_o)); // R3

   AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (width_i == '0 || height_i == '0)) |=> (done_o && !busy_o)); // R7

   AST_LOWBYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && !wr_tran_o && !start_i && !init_i) |=>
         (!busy_o || wr_addr_o[7:0] == $past(wr_addr_o[7:0]) + B1)); // R4

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_ready_o && !pix_valid_i && !start_i && !init_i) |=>
         (pix_ready_o && $stable(wr_addr_o))); // R10

   AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tran_o && !start_i && !init_i) |=>
         (!busy_o || wr_addr_o[FILL_AW-1:0] == $past(wr_addr_o[FILL_AW-1:0]) + F1)); // R8

endmodule

bind curs_sram_loader cursld_checker #(
   .ADDR_W      (ADDR_W),
   .DIM_W       (DIM_W),
   .FILL_AW     (FILL_AW),
   .BANK_A_BASE (BANK_A_BASE),
   .FILL_WORD   (FILL_WORD),
   .SWAP_RB     (SWAP_RB)
) u_cursld_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .init_i      (init_i),
   .width_i     (width_i),
   .height_i    (height_i),
   .pix_valid_i (pix_valid_i),
   .pix_data_i  (pix_data_i),
   .pix_ready_o (pix_ready_o),
   .wr_en_o     (wr_en_o),
   .wr_tran_o   (wr_tran_o),
   .wr_addr_o   (wr_addr_o),
   .wr_data_o   (wr_data_o),
   .busy_o      (busy_o),
   .done_o      (done_o)
);

// File: tb/tb_curs_sram_loader.sv
`timescale 1ns/1ps
module tb_curs_sram_loader;

   localparam int ADDR_W = 16;
   localparam int DIM_W  = 7;
   localparam int WDOG   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, init_i = 1'b0;
   logic [DIM_W-1:0] width_i = '0, height_i = '0;
   logic pix_valid_i = 1'b0;
   logic [31:0] pix_data_i = '0;
   logic pix_ready_o, wr_en_o, wr_tran_o, busy_o, done_o;
   logic [ADDR_W-1:0] wr_addr_o;
   logic [31:0] wr_data_o;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;
   always @(posedge clk) cycles <= cycles + 1;

   curs_sram_loader dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .init_i(init_i),
      .width_i(width_i), .height_i(height_i),
      .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i),
      .pix_ready_o(pix_ready_o), .wr_en_o(wr_en_o), .wr_tran_o(wr_tran_o),
      .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] next_addr(input logic [15:0] a);
      logic [15:0] t;
      t = a + 16'd1;
      if (t[7:0] == 8'h00) t = t + 16'h0F00;
      if ((t & 16'h30FF) == 16'h0000) t = 16'h0D00;
      return t;
   endfunction

   function automatic logic [31:0] pix_of(input int n);
      return (n * 32'h9E37_79B1) ^ 32'h1357_2468;
   endfunction

   function automatic logic [31:0] swapped(input logic [31:0] p);
      return {p[31:24], p[7:0], p[15:8], p[23:16]};
   endfunction

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   // Issues a load and streams pixels; stop_at >= 0 aborts after that many writes.
   task automatic run_load(input int w, input int h, input bit gappy, input bit with_init, input int stop_at);
      logic [15:0] exp_a;
      int n;
      int total;
      @(negedge clk);
      start_i = 1'b1; init_i = with_init; width_i = w[DIM_W-1:0]; height_i = h[DIM_W-1:0];
      pix_valid_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0; init_i = 1'b0;
      total = w * h;
      if (total == 0) begin
         #1;
         check(done_o == 1'b1 && busy_o == 1'b0, "R7 zero size done", {30'd0, done_o, busy_o}, 32'h2);
         check(wr_en_o == 1'b0, "R7 zero size no write", {31'd0, wr_en_o}, 32'd0);
         return;
      end
      #0;
      check(done_o == 1'b0, "R9 no done on restart", {31'd0, done_o}, 32'd0);
      exp_a = 16'h0C00;
      n = 0;
      while (n < total && (stop_at < 0 || n < stop_at)) begin
         step_lfsr();
         pix_valid_i = gappy ? (lfsr[1:0] != 2'b00) : 1'b1;
         pix_data_i  = pix_of(n + w);
         #1;
         if (pix_valid_i) begin
            check(wr_en_o && pix_ready_o && !wr_tran_o, "R6 write strobe", {29'd0, wr_en_o, pix_ready_o, wr_tran_o}, 32'h6);
            check(wr_addr_o == exp_a, (n == 0) ? "R3 first address" :
                  (exp_a[7:0] == 8'h00 && exp_a[11:8] == 4'hD) ? "R5 bank address" : "R4 address step",
                  {16'd0, wr_addr_o}, {16'd0, exp_a});
            check(wr_data_o == swapped(pix_data_i), "R2 lane swap", wr_data_o, swapped(pix_data_i));
            exp_a = next_addr(exp_a);
            n++;
         end else begin
            check(wr_en_o == 1'b0 && pix_ready_o, "R10 idle beat", {30'd0, wr_en_o, pix_ready_o}, 32'h1);
         end
         @(negedge clk);
      end
      pix_valid_i = 1'b0;
      if (stop_at >= 0 && n < total) return;
      #1;
      check(done_o == 1'b1 && busy_o == 1'b0 && pix_ready_o == 1'b0, "R6 done after last",
            {29'd0, done_o, busy_o, pix_ready_o}, 32'h4);
      @(negedge clk);
      #1;
      check(done_o == 1'b0, "R6 done single cycle", {31'd0, done_o}, 32'd0);
   endtask

   task automatic run_fill();
      @(negedge clk);
      init_i = 1'b1; pix_valid_i = 1'b0;
      @(negedge clk);
      init_i = 1'b0;
      for (int i = 0; i < 256; i++) begin
         pix_valid_i = lfsr[0];
         step_lfsr();
         #1;
         check(wr_en_o && wr_tran_o && !pix_ready_o, "R8 fill strobe", {29'd0, wr_en_o, wr_tran_o, pix_ready_o}, 32'h6);
         check(wr_addr_o == i[15:0], "R8 fill address", {16'd0, wr_addr_o}, i);
         check(wr_data_o == 32'h5555_5555, "R8 fill data", wr_data_o, 32'h5555_5555);
         @(negedge clk);
      end
      pix_valid_i = 1'b0;
      #1;
      check(done_o && !busy_o, "R8 fill done", {30'd0, done_o, busy_o}, 32'h2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(!wr_en_o && !pix_ready_o && !busy_o && !done_o, "R1 in reset",
            {28'd0, wr_en_o, pix_ready_o, busy_o, done_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(!wr_en_o && !pix_ready_o && !busy_o && !done_o, "R1 after reset",
            {28'd0, wr_en_o, pix_ready_o, busy_o, done_o}, 32'd0);

      // R6 sweep of small shapes, dense and gappy
      for (int w = 1; w <= 5; w++)
         for (int h = 1; h <= 4; h++)
            run_load(w, h, (w + h) % 2 == 1, 1'b0, -1);
      // R7 zero sizes
      run_load(0, 5, 1'b0, 1'b0, -1);
      run_load(6, 0, 1'b0, 1'b0, -1);
      run_load(0, 0, 1'b0, 1'b0, -1);
      // R4 R5 long load across all segment jumps and into the second bank
      run_load(32, 40, 1'b1, 1'b0, -1);
      // R8 fill
      run_fill();
      // R9 restart mid-load, then fill aborting a load, then simultaneous commands
      run_load(10, 10, 1'b0, 1'b0, 37);
      run_load(3, 2, 1'b1, 1'b0, -1);
      run_load(20, 20, 1'b0, 1'b0, 300);
      run_fill();
      run_load(2, 3, 1'b0, 1'b1, -1);
      // R3 restart at the exact final beat position of a long load
      run_load(16, 16, 1'b0, 1'b0, 255);
      run_load(17, 16, 1'b0, 1'b0, -1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      wait (cycles >= WDOG);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule